// File: doc/BRIEF.md
# Ring Resource Pair Allocator

A central allocator for a ring of N clients that share N resources. Resource k sits between client k and client k+1 (modulo N). Each client must hold both resources next to it before it may work: its left resource is resource k, and its right resource is resource k-1 modulo N. A client cannot take a resource by itself. It raises a request, and the allocator, which records who owns every resource, hands the pair over in two steps. The left resource is granted first and the right resource one cycle later.

Requests that cannot be served at once wait in a queue ordered by arrival. A parameter picks the service policy. In in-order mode only the oldest entry may be served, so a blocked head holds back every request behind it. In retry mode every waiting request is checked again on each cycle, and the oldest one whose pair is free is served. When a working client raises release, both of its resources are freed together.

Top module: `ring_pair_alloc`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no grant is raised, no client is active, the pending count is 0, `pend_empty` is 1 and `pend_full` is 0.
- R2: A request from an idle client is queued at the next rising edge and raises `pend_count` by one. Requests that arrive in the same cycle are queued in ascending client index, and in in-order mode they are served in that order.
- R3: A client is active only while the allocator records it as the owner of both resource k and resource k-1 mod N. No resource ever has two owners.
- R4: A left grant is a single-cycle pulse. The right grant for the same client follows in the very next cycle. The two grants of one client never occur in the same cycle.
- R5: `active[k]` rises in the cycle that carries `grant_right[k]` and stays high until the client releases.
- R6: When SERVE_IN_ORDER=1, only the head of the queue may be served. A head whose pair is busy blocks all later entries, even when their pairs are free.
- R7: When SERVE_IN_ORDER=0, each cycle serves the oldest queued entry whose two resources are free. Refused entries are checked again on every cycle.
- R8: A release from an active client frees both of its resources at the same edge, and `active` drops at that edge. No resource freed this way is granted before the following edge.
- R9: A request from a client that is not idle, and a release from a client that is not active, are both ignored.
- R10: The queue holds at most N entries. `pend_full` is 1 exactly when N requests are pending, and `pend_empty` is 1 exactly when none are.
- R11: Two neighbouring clients are never active in the same cycle.
- R12: At most one left grant is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Per-client request to acquire its pair |
| rel | input | N | Per-client release of its pair |
| grant_left | output | N | One-cycle pulse: resource k granted to client k |
| grant_right | output | N | One-cycle pulse: resource k-1 mod N granted to client k |
| active | output | N | Client holds both resources and is working |
| pend_count | output | clog2(N+1) | Number of queued requests |
| pend_empty | output | 1 | No request is queued |
| pend_full | output | 1 | N requests are queued |

## Verification
Each result is due a fixed number of edges after its stimulus. A request is counted at the next edge. A left grant comes one edge after the request reaches a servable position. The right grant and `active` come one edge after that. A release drops `active` at the edge that samples it, and a neighbour can get its left grant one edge later at the earliest. The bench drives each input at a falling edge and reads the outputs at the falling edge after every rising edge, so each check lands on the edge count above. The in-order and retry instances run the same blocking pattern, and their grant orders are compared against hand-derived sequences.

// File: rtl/ring_pair_alloc.sv
module ring_pair_alloc #(
  parameter int N = 5,
  parameter bit SERVE_IN_ORDER = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           req,
  input  logic [N-1:0]           rel,
  output logic [N-1:0]           grant_left,
  output logic [N-1:0]           grant_right,
  output logic [N-1:0]           active,
  output logic [$clog2(N+1)-1:0] pend_count,
  output logic                   pend_empty,
  output logic                   pend_full
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LEFT, S_EAT} cst_t;

  function automatic int rres(input int c);
    return (c == 0) ? N - 1 : c - 1;
  endfunction

  cst_t          st    [N];
  logic [N-1:0]  owned;
  logic [IW-1:0] owner [N];
  logic [N-1:0]  rsv;
  logic [IW-1:0] q_id  [N];
  logic [CW-1:0] q_cnt;

  logic [N-1:0]  busy, can_go, idle_m, enq;
  logic          sel_hit;
  logic [IW-1:0] sel_pos, sel_cli;
  logic [IW-1:0] n_id  [N];
  logic [CW-1:0] n_cnt;

  assign busy = owned | rsv;

  for (genvar g = 0; g < N; g++) begin : g_cli
    assign can_go[g] = !busy[g] && !busy[rres(g)];
    assign idle_m[g] = (st[g] == S_IDLE);
    assign active[g] = (st[g] == S_EAT);
  end

  assign enq        = req & idle_m;
  assign pend_count = q_cnt;
  assign pend_empty = (q_cnt == '0);
  assign pend_full  = (q_cnt == CW'(N));

  always_comb begin
    sel_hit = 1'b0;
    sel_pos = '0;
    sel_cli = '0;
    for (int i = 0; i < N; i++) begin
      if (!sel_hit && CW'(i) < q_cnt && (!SERVE_IN_ORDER || i == 0)) begin
        if (can_go[q_id[i]]) begin
          sel_hit = 1'b1;
          sel_pos = IW'(i);
          sel_cli = q_id[i];
        end
      end
    end
  end

  always_comb begin
    n_cnt = '0;
    for (int k = 0; k < N; k++) n_id[k] = '0;
    for (int i = 0; i < N; i++) begin
      if (CW'(i) < q_cnt && !(sel_hit && sel_pos == IW'(i))) begin
        n_id[IW'(n_cnt)] = q_id[i];
        n_cnt = n_cnt + 1'b1;
      end
    end
    for (int c = 0; c < N; c++) begin
      if (enq[c]) begin
        n_id[IW'(n_cnt)] = IW'(c);
        n_cnt = n_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned       <= '0;
      rsv         <= '0;
      q_cnt       <= '0;
      grant_left  <= '0;
      grant_right <= '0;
      for (int c = 0; c < N; c++) begin
        st[c]    <= S_IDLE;
        owner[c] <= '0;
        q_id[c]  <= '0;
      end
    end else begin
      grant_left  <= '0;
      grant_right <= '0;
      q_cnt       <= n_cnt;
      for (int k = 0; k < N; k++) q_id[k] <= n_id[k];
      for (int c = 0; c < N; c++) begin
        case (st[c])
          S_IDLE: if (enq[c]) st[c] <= S_WAIT;
          S_WAIT: if (sel_hit && sel_cli == IW'(c)) begin
            st[c]         <= S_LEFT;
            grant_left[c] <= 1'b1;
            owned[c]      <= 1'b1;
            owner[c]      <= IW'(c);
            rsv[rres(c)]  <= 1'b1;
          end
          S_LEFT: begin
            st[c]          <= S_EAT;
            grant_right[c] <= 1'b1;
            owned[rres(c)] <= 1'b1;
            owner[rres(c)] <= IW'(c);
            rsv[rres(c)]   <= 1'b0;
          end
          S_EAT: if (rel[c]) begin
            st[c]          <= S_IDLE;
            owned[c]       <= 1'b0;
            owned[rres(c)] <= 1'b0;
          end
          default: st[c] <= S_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_eat_owns_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active[g] |-> (owned[g] && owned[rres(g)] && owner[g] == IW'(g) && owner[rres(g)] == IW'(g)));
    p_right_after_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_right[g] |-> $past(grant_left[g]));
    p_grants_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_left[g] && grant_right[g]));
    p_eat_with_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grant_right[g] |-> active[g]);
    p_release_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active[g] && rel[g]) |=> (!active[g] && !owned[g] && !owned[rres(g)]));
    p_neighbours_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(active[g] && active[(g + 1) % N]));
    if (SERVE_IN_ORDER) begin : g_ord
      p_head_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_left[g] |-> $past(q_cnt != '0 && q_id[0] == IW'(g)));
    end
  end

  p_one_left_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_left));
  p_queue_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_count <= CW'(N)) && (pend_full == (pend_count == CW'(N))));
endmodule

// File: tb/ring_pair_alloc_tb.sv
module ring_pair_alloc_tb;
  localparam int N  = 5;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]  req_v [2];
  logic [N-1:0]  rel_v [2];
  logic [N-1:0]  gl    [2];
  logic [N-1:0]  gr    [2];
  logic [N-1:0]  act   [2];
  logic [CW-1:0] cnt   [2];
  logic          emp   [2];
  logic          ful   [2];

  ring_pair_alloc #(.N(N), .SERVE_IN_ORDER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req_v[0]), .rel(rel_v[0]),
    .grant_left(gl[0]), .grant_right(gr[0]), .active(act[0]),
    .pend_count(cnt[0]), .pend_empty(emp[0]), .pend_full(ful[0]));

  ring_pair_alloc #(.N(N), .SERVE_IN_ORDER(1'b0)) u_dut_rt (
    .clk(clk), .rst_n(rst_n), .req(req_v[1]), .rel(rel_v[1]),
    .grant_left(gl[1]), .grant_right(gr[1]), .active(act[1]),
    .pend_count(cnt[1]), .pend_empty(emp[1]), .pend_full(ful[1]));

  int checks = 0;
  int fails  = 0;
  int mon_nbr = 0;
  int mon_own = 0;
  int lg [2][20];
  int nl [2];
  int own_m [2][N];
  logic [N-1:0] prev_act [2];

  function automatic int rr(input int c);
    return (c == 0) ? N - 1 : c - 1;
  endfunction

  task automatic check(input string tag, input int a, input int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, a, e);
    end
  endtask

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        for (int k = 0; k < N; k++) own_m[d][k] = -1;
        prev_act[d] = '0;
      end else begin
        for (int c = 0; c < N; c++) begin
          if (prev_act[d][c] && !act[d][c]) begin
            if (own_m[d][c] == c) own_m[d][c] = -1;
            if (own_m[d][rr(c)] == c) own_m[d][rr(c)] = -1;
          end
        end
        for (int c = 0; c < N; c++) begin
          if (gl[d][c]) begin
            if (own_m[d][c] != -1) mon_own++;
            own_m[d][c] = c;
            if (nl[d] < 20) lg[d][nl[d]] = c;
            nl[d]++;
          end
          if (gr[d][c]) begin
            if (own_m[d][rr(c)] != -1) mon_own++;
            own_m[d][rr(c)] = c;
          end
        end
        for (int c = 0; c < N; c++) begin
          if (act[d][c] && act[d][(c + 1) % N]) mon_nbr++;
          if (act[d][c] && (own_m[d][c] != c || own_m[d][rr(c)] != c)) mon_own++;
        end
        prev_act[d] = act[d];
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_req(input int d, input logic [N-1:0] m);
    req_v[d] = m;
    @(negedge clk);
    req_v[d] = '0;
  endtask

  task automatic pulse_rel(input int d, input logic [N-1:0] m);
    rel_v[d] = m;
    @(negedge clk);
    rel_v[d] = '0;
  endtask

  task automatic drain(input int d);
    for (int k = 0; k < 80; k++) begin
      if (act[d] != '0) pulse_rel(d, act[d]);
      else if (cnt[d] == '0 && gl[d] == '0 && gr[d] == '0) break;
      else step();
    end
    check("R10 queue empty after drain", int'(emp[d]), 1);
    check("R5 nobody active after drain", int'(act[d]), 0);
  endtask

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      check("R1 reset grants", int'(gl[d] | gr[d]), 0);
      check("R1 reset active", int'(act[d]), 0);
      check("R1 reset count", int'(cnt[d]), 0);
      check("R1 reset empty/full", int'({emp[d], ful[d]}), 2);
    end
  endtask

  task automatic t_single();
    pulse_req(0, 5'b00001);
    check("R2 count after request", int'(cnt[0]), 1);
    check("R2 no grant yet", int'(gl[0]), 0);
    step();
    check("R4 left grant", int'(gl[0]), 1);
    check("R4 no right with left", int'(gr[0]), 0);
    check("R5 not active before right", int'(act[0]), 0);
    step();
    check("R4 right grant next cycle", int'(gr[0]), 1);
    check("R4 left pulse ended", int'(gl[0]), 0);
    check("R5 active with right", int'(act[0]), 1);
    step();
    check("R4 right pulse ended", int'(gr[0]), 0);
    check("R5 active held", int'(act[0]), 1);
    pulse_rel(0, 5'b00001);
    check("R8 active drops on release", int'(act[0]), 0);
  endtask

  task automatic t_block_inorder();
    pulse_req(0, 5'b00001);
    step(); step();
    check("R5 client0 active", int'(act[0]), 5'b00001);
    pulse_req(0, 5'b00010);
    pulse_req(0, 5'b01000);
    check("R2 two queued", int'(cnt[0]), 2);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R6 blocked head stalls client3", int'(gl[0]), 0);
      check("R6 count held", int'(cnt[0]), 2);
    end
    pulse_rel(0, 5'b00001);
    check("R8 released", int'(act[0]), 0);
    check("R8 no reuse at release edge", int'(gl[0]), 0);
    step();
    check("R8 neighbour granted next edge", int'(gl[0]), 5'b00010);
    step();
    check("R6 next head served", int'(gl[0]), 5'b01000);
    check("R4 right of client1", int'(gr[0]), 5'b00010);
    step();
    check("R11 clients 1 and 3 active", int'(act[0]), 5'b01010);
    pulse_rel(0, 5'b01010);
    drain(0);
  endtask

  task automatic t_block_retry();
    pulse_req(1, 5'b00001);
    step(); step();
    check("R5 retry client0 active", int'(act[1]), 5'b00001);
    pulse_req(1, 5'b00010);
    pulse_req(1, 5'b01000);
    check("R7 two queued", int'(cnt[1]), 2);
    check("R7 no grant yet", int'(gl[1]), 0);
    step();
    check("R7 later entry served past blocked one", int'(gl[1]), 5'b01000);
    check("R7 count after serve", int'(cnt[1]), 1);
    step();
    check("R7 clients 0 and 3 active", int'(act[1]), 5'b01001);
    pulse_rel(1, 5'b00001);
    step();
    check("R7 retried entry served", int'(gl[1]), 5'b00010);
    step();
    check("R11 retry clients 1 and 3", int'(act[1]), 5'b01010);
    pulse_rel(1, 5'b01010);
    drain(1);
  endtask

  task automatic t_ignored();
    pulse_req(0, 5'b00100);
    step(); step();
    check("R5 client2 active", int'(act[0]), 5'b00100);
    pulse_req(0, 5'b00100);
    check("R9 request from active ignored", int'(cnt[0]), 0);
    step();
    check("R9 no grant from ignored request", int'(gl[0]), 0);
    pulse_req(0, 5'b01000);
    check("R9 client3 queued", int'(cnt[0]), 1);
    pulse_rel(0, 5'b01000);
    check("R9 release from waiting client ignored", int'(cnt[0]), 1);
    check("R9 active unchanged", int'(act[0]), 5'b00100);
    step();
    check("R9 still blocked", int'(gl[0]), 0);
    pulse_rel(0, 5'b00100);
    step();
    check("R8 client3 served after release", int'(gl[0]), 5'b01000);
    drain(0);
  endtask

  task automatic t_all_inorder();
    nl[0] = 0;
    pulse_req(0, 5'b11111);
    check("R10 count full", int'(cnt[0]), N);
    check("R10 full flag", int'(ful[0]), 1);
    step();
    check("R2 lowest index first", int'(gl[0]), 5'b00001);
    check("R10 full cleared", int'(ful[0]), 0);
    step();
    check("R12 no second left grant", int'(gl[0]), 0);
    step();
    check("R6 head client1 blocks rest", int'(gl[0]), 0);
    check("R6 four pending", int'(cnt[0]), 4);
    drain(0);
    check("R2 served count", nl[0], 5);
    for (int k = 0; k < 5; k++) check("R2 in-order grant sequence", lg[0][k], k);
  endtask

  task automatic t_all_retry();
    nl[1] = 0;
    pulse_req(1, 5'b11111);
    check("R10 retry full", int'(ful[1]), 1);
    step();
    check("R7 oldest first", int'(gl[1]), 5'b00001);
    step();
    check("R7 oldest servable next", int'(gl[1]), 5'b00100);
    step();
    check("R7 clients 0 and 2 active", int'(act[1]), 5'b00101);
    check("R7 three pending", int'(cnt[1]), 3);
    drain(1);
    check("R7 served count", nl[1], 5);
    check("R7 order 3rd", lg[1][2], 1);
    check("R7 order 4th", lg[1][3], 3);
    check("R7 order 5th", lg[1][4], 4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      req_v[d] = '0;
      rel_v[d] = '0;
      nl[d] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_block_inorder();
    t_block_retry();
    t_ignored();
    t_all_inorder();
    t_all_retry();
    check("R11 neighbours never active together", mon_nbr, 0);
    check("R3 single owner per resource", mon_own, 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R12 run did not complete: actual timeout expected finish");
    finish_run();
  end
endmodule